// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog with a small word-wide register port. Software programs a preset value and keeps the timer from running out by writing the reload register. The count steps down once per tick. A parameterised prescaler derives the tick from the clock, so a bench can use a short tick period.

If software stops servicing the timer, expiry is handled in two stages. The first expiry flags a timeout, optionally pulses a system-management interrupt (SMI) request and restarts the count. The second consecutive expiry records boot-failure status and raises a reset request. A speaker strap pin driven high, or an asserted no-reboot input, vetoes that reset; in that case the timer carries on as it would after a first expiry.

The register set also holds a mailbox pair, two message bytes, a watchdog-count byte, a software interrupt byte and an auxiliary control word. Writing the inbound mailbox byte raises an SMI request. The block resets asynchronously on an active-low input, and the release is synchronised inside the block.

Top module: `wdt_top`

## Requirements
- R1: After reset the registers read as follows: preset (address 2) = 4, auxiliary control (address 1) = 0x0008, software interrupt byte (address 8) = 0x03. Control (0), reload (3), status (4), boot status (5), inbound mailbox (6), outbound mailbox (7), watchdog-count (9), message A (10) and message B (11) read 0. The timer is idle and `reset_req` is low.
- R2: The timer may run only while the halt bit (control bit 0) is clear and the preset is greater than 1. A preset of 0 or 1 never starts it.
- R3: Any write to the reload register clears the consecutive-timeout history. If the timer may run, the count is loaded from the preset and counting restarts. Otherwise the written word is stored and reads back unchanged.
- R4: While running, the count drops by one every TICK_DIV clocks. The count expires preset×TICK_DIV clocks after a load. Each expiry sets the timeout bit (status bit 0).
- R5: An expiry that does not lead to a reset pulses `smi_req` for one clock when `smi_en` is high, and restarts the count from the preset. With `smi_en` low, no pulse is produced.
- R6: On the second consecutive expiry, boot status bits 0 (second timeout) and 1 (boot failure) are set and the history is cleared. If `strap_hi` and `no_reboot` are both low, `reset_req` rises and stays high until reset, the timer stops and no SMI pulse is produced. Otherwise R5 applies.
- R7: The lock bit (control bit 1) is sticky. Once written as 1, a later write of 0 leaves it at 1 until reset.
- R8: Every control write re-evaluates R2 with the new halt bit. If the timer may run, the count reloads from the preset; if not, the timer stops.
- R9: A write to the inbound mailbox stores the low byte, sets status bit 1 and pulses `smi_req`. A write to the outbound mailbox stores the low byte, sets status bit 2 and raises no SMI.
- R10: Status writes keep only bits 2:0, and boot-status writes keep only bits 1:0.
- R11: While the timer runs, a reload read returns the remaining count in bits CNT_W-1:0 and the stored upper bits above. While it is stopped, the read returns the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| smi_en | input | 1 | Allows SMI pulses on timer expiry |
| strap_hi | input | 1 | Speaker strap; high vetoes the reset |
| no_reboot | input | 1 | High vetoes the reset |
| smi_req | output | 1 | One-clock SMI request pulse |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The expiry path is exercised under every combination of veto inputs. With `strap_hi` high and with `no_reboot` high, two expiries must give two SMI pulses and boot status with no reset. With both vetoes low, the second expiry must give a reset instead of a second pulse. Each SMI and reset event is scored against a predicted clock cycle.

A reload written between the two expiries must push the boot status one full period later, which separates clearing the history from merely reloading the count. Presets of 0 and 1, halt, and `smi_en` low must each produce no event at all. Reload reads are checked both mid-count and while stopped, which separates the live count from the stored word.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL      = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL_AUX  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRESET    = 4'd2;
  localparam logic [ADDR_W-1:0] A_RELOAD    = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT      = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT_BOOT = 4'd5;
  localparam logic [ADDR_W-1:0] A_MBOX_IN   = 4'd6;
  localparam logic [ADDR_W-1:0] A_MBOX_OUT  = 4'd7;
  localparam logic [ADDR_W-1:0] A_IRQGEN    = 4'd8;
  localparam logic [ADDR_W-1:0] A_WDCOUNT   = 4'd9;
  localparam logic [ADDR_W-1:0] A_NOTE_A    = 4'd10;
  localparam logic [ADDR_W-1:0] A_NOTE_B    = 4'd11;

  // bit positions
  localparam int ST_TIMEOUT = 0;
  localparam int ST_SWSMI   = 1;
  localparam int ST_OUTINT  = 2;
  localparam logic [DATA_W-1:0] ST_MASK = 16'h0007;
  localparam int SB_SECOND  = 0;
  localparam int SB_BOOT    = 1;
  localparam logic [DATA_W-1:0] SB_MASK = 16'h0003;
  localparam int CT_HALT    = 0;
  localparam int CT_LOCK    = 1;
  localparam logic [DATA_W-1:0] CT_MASK = 16'h0003;

  localparam logic [DATA_W-1:0] CTRL_AUX_RST = 16'h0008;
  localparam logic [7:0]        IRQGEN_RST   = 8'h03;
  localparam int                PRESET_RST   = 4;

  typedef struct packed {
    logic [DATA_W-1:0] ctrl;
    logic [DATA_W-1:0] ctrl_aux;
    logic [DATA_W-1:0] reload;
    logic [DATA_W-1:0] stat;
    logic [DATA_W-1:0] stat_boot;
    logic [7:0]        mbox_in;
    logic [7:0]        mbox_out;
    logic [7:0]        irqgen;
    logic [7:0]        wdcount;
    logic [7:0]        note_a;
    logic [7:0]        note_b;
  } wdt_regs_s;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;

  assign tick = run && (pcnt_q == LAST);

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart || !run)  pcnt_d = '0;
    else if (tick)        pcnt_d = '0;
    else                  pcnt_d = pcnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R4: ticks are spaced apart, never back to back
      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] init_val,
  input  logic             cmd_load,
  input  logic             cmd_stop,
  input  logic             cmd_clr,
  input  logic             strap_hi,
  input  logic             no_reboot,
  output logic             running,
  output logic [CNT_W-1:0] remaining,
  output logic             exp_evt,
  output logic             exp_second,
  output logic             exp_reset,
  output logic             reset_req
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             seen_q, seen_d;   // one expiry already seen
  logic             rr_q, rr_d;

  // register writes take priority over an expiry in the same cycle
  assign exp_evt    = tick && run_q && (rem_q == CNT_W'(1)) &&
                      !(cmd_load || cmd_stop || cmd_clr);
  assign exp_second = exp_evt && seen_q;
  assign exp_reset  = exp_second && !strap_hi && !no_reboot;

  always_comb begin
    run_d  = run_q;
    rem_d  = rem_q;
    seen_d = seen_q;
    rr_d   = rr_q;
    if (cmd_load) begin
      run_d = 1'b1;
      rem_d = init_val;
    end else if (cmd_stop) begin
      run_d = 1'b0;
    end else if (exp_evt) begin
      seen_d = !exp_second;
      if (exp_reset) begin
        run_d = 1'b0;
        rr_d  = 1'b1;
      end else begin
        rem_d = init_val;
      end
    end else if (tick && run_q) begin
      rem_d = rem_q - CNT_W'(1);
    end
    if (cmd_clr) seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rem_q  <= '0;
      seen_q <= 1'b0;
      rr_q   <= 1'b0;
    end else begin
      run_q  <= run_d;
      rem_q  <= rem_d;
      seen_q <= seen_d;
      rr_q   <= rr_d;
    end
  end

  assign running   = run_q;
  assign remaining = rem_q;
  assign reset_req = rr_q;

  // R6: reset request holds once raised
  a_r6_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req);
  // R6: a resetting expiry stops the timer
  a_r6_reset_stops: assert property (@(posedge clk) disable iff (!rst_n)
    exp_reset |=> (reset_req && !running));
  // R2: the timer only starts with a preset above 1
  a_r2_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> ($past(init_val) > CNT_W'(1)));
  // R4: one step down per tick
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && rem_q > CNT_W'(1) && !cmd_load && !cmd_stop)
      |=> (remaining == $past(rem_q) - CNT_W'(1)));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              smi_en,
  input  logic              running,
  input  logic [CNT_W-1:0]  remaining,
  input  logic              exp_evt,
  input  logic              exp_second,
  input  logic              exp_reset,
  output logic [CNT_W-1:0]  init_val,
  output logic              cmd_load,
  output logic              cmd_stop,
  output logic              cmd_clr,
  output logic              smi_req
);
  wdt_regs_s        r_q, r_d;
  logic [CNT_W-1:0] preset_q, preset_d;
  logic             smi_q, smi_d;
  logic [DATA_W-1:0] ctrl_new;
  logic             w_ctrl, w_reload;

  assign w_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign w_reload = wr_en && (wr_addr == A_RELOAD);
  assign ctrl_new = (wr_data & CT_MASK) | (r_q.ctrl & (DATA_W'(1) << CT_LOCK));

  always_comb begin
    cmd_clr  = w_reload;
    cmd_load = 1'b0;
    cmd_stop = 1'b0;
    if (w_reload)
      cmd_load = !r_q.ctrl[CT_HALT] && (preset_q > CNT_W'(1));
    if (w_ctrl) begin
      cmd_load = !ctrl_new[CT_HALT] && (preset_q > CNT_W'(1));
      cmd_stop = !cmd_load;
    end
  end

  always_comb begin
    r_d      = r_q;
    preset_d = preset_q;
    smi_d    = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL:      r_d.ctrl      = ctrl_new;
        A_CTRL_AUX:  r_d.ctrl_aux  = wr_data;
        A_PRESET:    preset_d      = wr_data[CNT_W-1:0];
        A_RELOAD:    r_d.reload    = cmd_load ? DATA_W'(preset_q) : wr_data;
        A_STAT:      r_d.stat      = wr_data & ST_MASK;
        A_STAT_BOOT: r_d.stat_boot = wr_data & SB_MASK;
        A_MBOX_IN: begin
          r_d.mbox_in            = wr_data[7:0];
          r_d.stat[ST_SWSMI]     = 1'b1;
          smi_d                  = 1'b1;
        end
        A_MBOX_OUT: begin
          r_d.mbox_out           = wr_data[7:0];
          r_d.stat[ST_OUTINT]    = 1'b1;
        end
        A_IRQGEN:    r_d.irqgen    = wr_data[7:0];
        A_WDCOUNT:   r_d.wdcount   = wr_data[7:0];
        A_NOTE_A:    r_d.note_a    = wr_data[7:0];
        A_NOTE_B:    r_d.note_b    = wr_data[7:0];
        default: ;
      endcase
      if (w_ctrl && cmd_load) r_d.reload = DATA_W'(preset_q);
    end
    if (exp_evt) begin
      r_d.stat[ST_TIMEOUT] = 1'b1;
      r_d.reload           = exp_reset ? '0 : DATA_W'(preset_q);
      if (!exp_reset && smi_en) smi_d = 1'b1;
    end
    if (exp_second) begin
      r_d.stat_boot[SB_SECOND] = 1'b1;
      r_d.stat_boot[SB_BOOT]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q          <= '0;
      r_q.ctrl_aux <= CTRL_AUX_RST;
      r_q.irqgen   <= IRQGEN_RST;
      preset_q     <= CNT_W'(PRESET_RST);
      smi_q        <= 1'b0;
    end else begin
      r_q          <= r_d;
      preset_q     <= preset_d;
      smi_q        <= smi_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:      rd_data = r_q.ctrl;
      A_CTRL_AUX:  rd_data = r_q.ctrl_aux;
      A_PRESET:    rd_data = DATA_W'(preset_q);
      A_RELOAD:    rd_data = running ? {r_q.reload[DATA_W-1:CNT_W], remaining}
                                     : r_q.reload;
      A_STAT:      rd_data = r_q.stat;
      A_STAT_BOOT: rd_data = r_q.stat_boot;
      A_MBOX_IN:   rd_data = DATA_W'(r_q.mbox_in);
      A_MBOX_OUT:  rd_data = DATA_W'(r_q.mbox_out);
      A_IRQGEN:    rd_data = DATA_W'(r_q.irqgen);
      A_WDCOUNT:   rd_data = DATA_W'(r_q.wdcount);
      A_NOTE_A:    rd_data = DATA_W'(r_q.note_a);
      A_NOTE_B:    rd_data = DATA_W'(r_q.note_b);
      default:     rd_data = '0;
    endcase
  end

  assign init_val = preset_q;
  assign smi_req  = smi_q;

  // R7: lock bit never falls while out of reset
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    r_q.ctrl[CT_LOCK] |=> r_q.ctrl[CT_LOCK]);
  // R9: inbound mailbox write pulses an SMI request
  a_r9_mbox_smi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MBOX_IN) |=> smi_req);
  // R8: writing halt stops the timer
  a_r8_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && wr_data[CT_HALT]) |=> !running);
  // R5: SMI pulses last one clock unless a write re-triggers
  a_r5_smi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && !(wr_en && wr_addr == A_MBOX_IN) && !exp_evt) |=> !smi_req);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int TICK_DIV = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic        smi_en,
  input  logic        strap_hi,
  input  logic        no_reboot,
  output logic        smi_req,
  output logic        reset_req
);
  logic [1:0]       rsync_q;
  logic             rst_sn;
  logic             tick, running, exp_evt, exp_second, exp_reset;
  logic             cmd_load, cmd_stop, cmd_clr;
  logic [CNT_W-1:0] remaining, init_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  wdt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_sn), .run(running),
    .restart(cmd_load || exp_evt), .tick(tick)
  );

  wdt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_sn), .tick(tick), .init_val(init_val),
    .cmd_load(cmd_load), .cmd_stop(cmd_stop), .cmd_clr(cmd_clr),
    .strap_hi(strap_hi), .no_reboot(no_reboot), .running(running),
    .remaining(remaining), .exp_evt(exp_evt), .exp_second(exp_second),
    .exp_reset(exp_reset), .reset_req(reset_req)
  );

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .smi_en(smi_en), .running(running), .remaining(remaining),
    .exp_evt(exp_evt), .exp_second(exp_second), .exp_reset(exp_reset),
    .init_val(init_val), .cmd_load(cmd_load), .cmd_stop(cmd_stop),
    .cmd_clr(cmd_clr), .smi_req(smi_req)
  );
endmodule

// File: tb/wdt_top_bench.sv
module wdt_top_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        smi_en = 1'b1;
  logic        strap_hi = 1'b1;
  logic        no_reboot = 1'b0;
  logic        smi_req, reset_req;

  wdt_top #(.CNT_W(10), .TICK_DIV(DIV)) u_wdt_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .smi_en(smi_en), .strap_hi(strap_hi), .no_reboot(no_reboot),
    .smi_req(smi_req), .reset_req(reset_req)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int last_c = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int kind; int at; string req; } ev_t;  // kind 0 = SMI, 1 = reset
  ev_t expq[$];

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(int kind, int at, string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    expq.push_back(e);
  endtask

  // monitor: scores every SMI pulse and reset rise against the queue
  logic prev_rr = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (smi_req || (reset_req && !prev_rr)) begin
        automatic int k = smi_req ? 0 : 1;
        n_chk++;
        if (expq.size() == 0) begin
          n_fail++;
          $display("FAIL R5/R6 unexpected event kind=%0d at cycle %0d expected none", k, cyc);
        end else begin
          automatic ev_t e = expq.pop_front();
          if (e.kind != k || cyc < e.at - 2 || cyc > e.at + 2) begin
            n_fail++;
            $display("FAIL %s event kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                     e.req, k, cyc, e.kind, e.at);
          end
        end
      end
      prev_rr = reset_req;
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d, bit exp_smi = 0, string req = "R9");
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    last_c = cyc + 1;
    if (exp_smi) push(0, last_c, req);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic rchk(string req, logic [3:0] a, logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c0;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset values
    rchk("R1 ctrl", 4'd0, 16'h0000);
    rchk("R1 ctrl_aux", 4'd1, 16'h0008);
    rchk("R1 preset", 4'd2, 16'h0004);
    rchk("R1 reload", 4'd3, 16'h0000);
    rchk("R1 stat", 4'd4, 16'h0000);
    rchk("R1 stat_boot", 4'd5, 16'h0000);
    rchk("R1 irqgen", 4'd8, 16'h0003);
    rchk("R1 note_b", 4'd11, 16'h0000);
    chk("R1 reset_req", {15'd0, reset_req}, 16'h0000);
    repeat (40) @(negedge clk);  // R1 idle: scoreboard sees no event

    // R4/R5/R6 strap high: two expiries, boot status, no reset
    strap_hi = 1'b1; no_reboot = 1'b0;
    wr(4'd3, 16'h0000);
    c0 = last_c;
    push(0, c0 + 16, "R5 first expiry");
    push(0, c0 + 32, "R6 strap veto expiry");
    wait_until(c0 + 20);
    rchk("R4 timeout bit", 4'd4, 16'h0001);
    rchk("R5 no boot status after first", 4'd5, 16'h0000);
    wait_until(c0 + 36);
    rchk("R6 boot status strap", 4'd5, 16'h0003);
    chk("R6 strap vetoes reset", {15'd0, reset_req}, 16'h0000);
    wr(4'd0, 16'h0001);  // R8 halt
    repeat (60) @(negedge clk);
    rchk("R11 stopped reload", 4'd3, 16'h0004);

    // R3 reload clears the history
    wr(4'd5, 16'h0000);
    wr(4'd4, 16'h0000);
    wr(4'd0, 16'h0000);  // R8 restart
    c0 = last_c;
    push(0, c0 + 16, "R8 restart expiry");
    wait_until(c0 + 20);
    wr(4'd3, 16'h0000);
    c0 = last_c;
    push(0, c0 + 16, "R3 expiry after reload");
    push(0, c0 + 32, "R3 second expiry");
    wait_until(c0 + 20);
    rchk("R3 history cleared", 4'd5, 16'h0000);
    wait_until(c0 + 36);
    rchk("R3 second expiry status", 4'd5, 16'h0003);
    wr(4'd0, 16'h0001);

    // R5 smi_en low: timeout bit but no pulse
    smi_en = 1'b0;
    wr(4'd4, 16'h0000);
    wr(4'd0, 16'h0000);
    c0 = last_c;
    wait_until(c0 + 20);
    rchk("R5 timeout without smi", 4'd4, 16'h0001);
    wr(4'd0, 16'h0001);
    smi_en = 1'b1;

    // R2 presets 0 and 1 never start; R3 stores written value
    wr(4'd2, 16'h0001);
    wr(4'd0, 16'h0000);
    wr(4'd3, 16'h0155);
    repeat (30) @(negedge clk);
    rchk("R2 preset 1 stored reload", 4'd3, 16'h0155);
    wr(4'd2, 16'h0000);
    wr(4'd3, 16'hFC5A);
    repeat (30) @(negedge clk);
    rchk("R11 stopped upper bits kept", 4'd3, 16'hFC5A);

    // R11 live count readback
    wr(4'd2, 16'd20);
    wr(4'd0, 16'h0000);
    c0 = last_c;
    wait_until(c0 + 10);
    rd(4'd3, v);
    n_chk++;
    if (v < 16'd17 || v > 16'd19) begin
      n_fail++;
      $display("FAIL R11 live count actual=%0d expected=18", v);
    end
    wr(4'd0, 16'h0001);
    rchk("R11 stored after halt", 4'd3, 16'd20);

    // R7 sticky lock
    wr(4'd0, 16'h0003);
    rchk("R7 lock set", 4'd0, 16'h0003);
    wr(4'd0, 16'h0000);
    rchk("R7 lock kept", 4'd0, 16'h0002);
    wr(4'd0, 16'h0001);
    rchk("R7 lock with halt", 4'd0, 16'h0003);

    // R9 mailboxes
    wr(4'd4, 16'h0000);
    wr(4'd6, 16'hAB5A, 1, "R9 inbound smi");
    rchk("R9 inbound data", 4'd6, 16'h005A);
    rchk("R9 sw smi bit", 4'd4, 16'h0002);
    wr(4'd7, 16'hCDA5);
    rchk("R9 outbound data", 4'd7, 16'h00A5);
    rchk("R9 out int bit", 4'd4, 16'h0006);

    // R10 masking
    wr(4'd4, 16'hFFFF);
    rchk("R10 stat mask", 4'd4, 16'h0007);
    wr(4'd5, 16'hFFFF);
    rchk("R10 boot mask", 4'd5, 16'h0003);

    // R6 no_reboot veto
    wr(4'd5, 16'h0000);
    wr(4'd2, 16'd4);
    strap_hi = 1'b0; no_reboot = 1'b1;
    wr(4'd0, 16'h0000);
    c0 = last_c;
    push(0, c0 + 16, "R6 noreboot first");
    push(0, c0 + 32, "R6 noreboot second");
    wait_until(c0 + 36);
    rchk("R6 boot status noreboot", 4'd5, 16'h0003);
    chk("R6 noreboot vetoes reset", {15'd0, reset_req}, 16'h0000);
    wr(4'd0, 16'h0001);

    // R6 reset path
    no_reboot = 1'b0;
    wr(4'd5, 16'h0000);
    wr(4'd0, 16'h0000);
    c0 = last_c;
    push(0, c0 + 16, "R6 first before reset");
    push(1, c0 + 32, "R6 reset request");
    wait_until(c0 + 50);
    chk("R6 reset raised", {15'd0, reset_req}, 16'h0001);
    rchk("R6 boot status reset", 4'd5, 16'h0003);
    rchk("R6 reload zero after reset stop", 4'd3, 16'h0000);
    repeat (40) @(negedge clk);
    chk("R6 reset held", {15'd0, reset_req}, 16'h0001);

    n_chk++;
    if (expq.size() != 0) begin
      n_fail++;
      $display("FAIL R5/R6 missing events actual=%0d expected=0", expq.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule